// File: doc/BRIEF.md
# SPI Target Shift Engine

This block is the target (slave) end of an SPI link, clocked by a fast on-chip system clock. The remote controller supplies the serial clock, an active-low select and the serial input line. The block brings all three into its own clock domain through two-flop synchronizers, finds their edges, and counts serial clock edges against a limit of twice the frame length minus one. A transmit shifter drives the serial output line and a receive shifter collects the serial input line.

On the host side there is a one-word transmit buffer with an empty flag and a one-word receive register with a full flag. The host uses either flag directly as an interrupt or DMA request. An underrun flag records that a frame started with no fresh transmit word. Three static inputs select the clock phase, a frame of 8 or 16 bits, and the bit order. These inputs must not change while select is asserted. Clock polarity is fixed: the serial clock idles low. The block never drives the serial clock.

Top module: `spi_target_engine`

## Requirements
- R1: After reset, `tx_empty` is 1, `rx_full` and `tx_underrun` are 0, `rx_word` is 0 and `miso_pin` is 0.
- R2: With `cfg_cpha`=0, assertion of `cs_n_pin` loads the buffered word into the transmit shifter, sets `tx_empty`, and presents the first bit on `miso_pin` before the first rising serial clock edge. Each later bit appears after a falling edge.
- R3: With `cfg_cpha`=0, `mosi_pin` is sampled on rising edges. After the last of 2×bits edges, `rx_word` holds the frame and `rx_full` is set.
- R4: With `cfg_cpha`=0, the last edge of a frame reloads the transmit shifter from the buffer, so back-to-back frames run under one continuous select assertion.
- R5: With `cfg_cpha`=1, the first rising edge loads the buffered word, `miso_pin` changes on rising edges, and `mosi_pin` is sampled on falling edges. Only one frame is taken per select assertion; further serial clock edges are ignored until select deasserts.
- R6: `cfg_wide`=1 selects 16-bit frames and `cfg_wide`=0 selects 8-bit frames. In 8-bit frames only `tx_word[7:0]` is sent and `rx_word[15:8]` reads 0.
- R7: `cfg_lsb_first`=1 sends and assembles bit 0 first; `cfg_lsb_first`=0 sends the top bit of the frame first.
- R8: A `tx_wr` pulse stores `tx_word` and clears both `tx_empty` and `tx_underrun` on the next clock.
- R9: A load that finds `tx_empty`=1 sets `tx_underrun` and sends the previously buffered word again.
- R10: An `rx_rd` pulse clears `rx_full` on the next clock, unless a frame completes in that same cycle.
- R11: `miso_pin` is 0 while select is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4× the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_pin | input | 1 | Serial clock from the controller, idle low |
| cs_n_pin | input | 1 | Active-low select from the controller |
| mosi_pin | input | 1 | Serial data from the controller |
| miso_pin | output | 1 | Serial data to the controller |
| cfg_cpha | input | 1 | Clock phase: 0 = sample on rising edge, 1 = sample on falling edge |
| cfg_wide | input | 1 | 1 = 16-bit frame, 0 = 8-bit frame |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| tx_word | input | 16 | Word to transmit |
| tx_wr | input | 1 | Write strobe for `tx_word` |
| tx_empty | output | 1 | Transmit buffer empty; usable as a request |
| tx_underrun | output | 1 | A frame loaded with no fresh word |
| rx_word | output | 16 | Last received frame |
| rx_rd | input | 1 | Read strobe that releases `rx_word` |
| rx_full | output | 1 | Receive register holds an unread frame; usable as a request |

## Verification
A change on any serial pin takes effect three system clocks after the change. Two clocks are spent in the synchronizer and one in the edge-detect register. Host strobes update the flags on the very next clock. The bench updates its behavioural model at the moment it drives a stimulus, then holds a six-clock quiet window before it compares the flags and the received word again. Outside that window it compares them on every clock. It checks the serial output line just before each sampling edge, at least four clocks after the edge that moved it.

// File: rtl/spi_target_engine.sv
module spi_target_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_pin,
  input  logic        cs_n_pin,
  input  logic        mosi_pin,
  output logic        miso_pin,
  input  logic        cfg_cpha,
  input  logic        cfg_wide,
  input  logic        cfg_lsb_first,
  input  logic [15:0] tx_word,
  input  logic        tx_wr,
  output logic        tx_empty,
  output logic        tx_underrun,
  output logic [15:0] rx_word,
  input  logic        rx_rd,
  output logic        rx_full
);
  localparam int WMAX = 16;
  localparam int CW   = $clog2(2 * WMAX);

  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck_pin};
      cs_q   <= {cs_q[1:0], cs_n_pin};
      mosi_q <= {mosi_q[0], mosi_pin};
    end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_start = ~cs_q[1] & cs_q[2];
  wire cs_stop  = cs_q[1] & ~cs_q[2];
  wire mosi_b   = mosi_q[1];

  logic            active, done;
  logic [CW-1:0]   cnt;
  logic [WMAX-1:0] tx_buf, tx_sh, rx_sh, rx_nxt;

  wire [CW-1:0] top = cfg_wide ? CW'(2 * WMAX - 1) : CW'(WMAX - 1);
  wire run      = active & ~done;
  wire e_rise   = run & sck_rise;
  wire e_fall   = run & sck_fall;
  wire e_any    = e_rise | e_fall;
  wire last     = (cnt == '0);
  wire sample   = cfg_cpha ? e_fall : e_rise;
  wire shift_e  = cfg_cpha ? e_rise : e_fall;
  wire load     = cfg_cpha ? (e_rise & (cnt == top)) : (cs_start | (e_fall & last));
  wire shift    = shift_e & ~load;
  wire capture  = e_any & last;
  wire out_bit  = cfg_lsb_first ? tx_sh[0] : (cfg_wide ? tx_sh[WMAX-1] : tx_sh[WMAX/2-1]);

  assign miso_pin = active & out_bit;

  always_comb begin
    rx_nxt = rx_sh;
    if (sample) begin
      if (!cfg_lsb_first) rx_nxt = {rx_sh[WMAX-2:0], mosi_b};
      else if (cfg_wide)  rx_nxt = {mosi_b, rx_sh[WMAX-1:1]};
      else                rx_nxt = {{(WMAX/2){1'b0}}, mosi_b, rx_sh[WMAX/2-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active      <= 1'b0;
      done        <= 1'b0;
      cnt         <= '0;
      tx_buf      <= '0;
      tx_sh       <= '0;
      rx_sh       <= '0;
      rx_word     <= '0;
      rx_full     <= 1'b0;
      tx_empty    <= 1'b1;
      tx_underrun <= 1'b0;
    end else begin
      if (cs_start)     active <= 1'b1;
      else if (cs_stop) active <= 1'b0;

      if (cs_start)                 done <= 1'b0;
      else if (capture && cfg_cpha) done <= 1'b1;

      if (cs_start)   cnt <= top;
      else if (e_any) cnt <= last ? top : cnt - 1'b1;

      if (load)       tx_sh <= tx_buf;
      else if (shift) tx_sh <= cfg_lsb_first ? {1'b0, tx_sh[WMAX-1:1]} : {tx_sh[WMAX-2:0], 1'b0};

      rx_sh <= rx_nxt;
      if (capture) rx_word <= cfg_wide ? rx_nxt : {{(WMAX/2){1'b0}}, rx_nxt[WMAX/2-1:0]};

      if (capture)     rx_full <= 1'b1;
      else if (rx_rd)  rx_full <= 1'b0;

      if (tx_wr) tx_buf <= tx_word;

      if (tx_wr)     tx_empty <= 1'b0;
      else if (load) tx_empty <= 1'b1;

      if (tx_wr)                 tx_underrun <= 1'b0;
      else if (load && tx_empty) tx_underrun <= 1'b1;
    end

  a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> (!tx_empty && !tx_underrun));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !capture) |=> !rx_full);

  a_r9_underrun_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_underrun) |-> $past(tx_empty));

  a_r3_capture_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(sck_rise || sck_fall));

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q[1] && cs_q[2]) |-> !miso_pin);

  a_r5_one_frame_per_select: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cs_start) |=> $stable(rx_word));
endmodule

// File: tb/tb_spi_target_engine.sv
module tb_spi_target_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck_pin = 1'b0, cs_n_pin = 1'b1, mosi_pin = 1'b0;
  logic miso_pin;
  logic cfg_cpha = 1'b0, cfg_wide = 1'b0, cfg_lsb_first = 1'b0;
  logic [15:0] tx_word = '0;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic tx_empty, tx_underrun, rx_full;
  logic [15:0] rx_word;

  always #2.5 clk = ~clk;

  spi_target_engine dut (
    .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .cs_n_pin(cs_n_pin), .mosi_pin(mosi_pin),
    .miso_pin(miso_pin), .cfg_cpha(cfg_cpha), .cfg_wide(cfg_wide), .cfg_lsb_first(cfg_lsb_first),
    .tx_word(tx_word), .tx_wr(tx_wr), .tx_empty(tx_empty), .tx_underrun(tx_underrun),
    .rx_word(rx_word), .rx_rd(rx_rd), .rx_full(rx_full));

  int tests = 0, fails = 0, quiet = 0;
  bit started = 0, finished = 0;
  string ctx = "R1";

  logic [15:0] m_buf = '0, m_cur = '0, m_rx = '0;
  logic m_empty = 1'b1, m_under = 1'b0, m_full = 1'b0;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s [%s] got %h expected %h", tag, ctx, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (started && rst_n) begin
      if (quiet > 0) quiet--;
      else begin
        chk("R8 tx_empty", {15'd0, tx_empty}, {15'd0, m_empty});
        chk("R9 tx_underrun", {15'd0, tx_underrun}, {15'd0, m_under});
        chk("R10 rx_full", {15'd0, rx_full}, {15'd0, m_full});
        chk("R3 rx_word", rx_word, m_rx);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog [%s] got timeout expected completion", ctx);
    summary();
  end

  function automatic int nbits();
    return cfg_wide ? 16 : 8;
  endfunction

  function automatic logic bit_at(input logic [15:0] w, input int i);
    int idx;
    idx = cfg_lsb_first ? i : nbits() - 1 - i;
    return w[idx];
  endfunction

  function automatic logic [15:0] masked(input logic [15:0] w);
    return cfg_wide ? w : {8'h00, w[7:0]};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_load();
    if (m_empty) m_under = 1'b1;
    m_cur   = m_buf;
    m_empty = 1'b1;
  endtask

  task automatic host_write(input logic [15:0] d);
    @(negedge clk);
    tx_word = d; tx_wr = 1'b1;
    m_buf = d; m_empty = 1'b0; m_under = 1'b0; quiet = 6;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk);
    rx_rd = 1'b1; m_full = 1'b0; quiet = 6;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n_pin = 1'b0; quiet = 6;
    if (!cfg_cpha) model_load();
    wait_n(6);
  endtask

  task automatic cs_high();
    @(negedge clk);
    cs_n_pin = 1'b1; quiet = 6;
    wait_n(6);
    chk("R11 idle miso", {15'd0, miso_pin}, 16'd0);
  endtask

  task automatic frame(input logic [15:0] mw);
    int b;
    b = nbits();
    for (int i = 0; i < b; i++) begin
      if (!cfg_cpha) begin
        mosi_pin = bit_at(mw, i);
        wait_n(4);
        chk("R2 miso bit", {15'd0, miso_pin}, {15'd0, bit_at(m_cur, i)});
        sck_pin = 1'b1; quiet = 6;
        wait_n(6);
        sck_pin = 1'b0; quiet = 6;
        if (i == b - 1) begin
          m_rx = masked(mw); m_full = 1'b1;
          model_load();
        end
        wait_n(2);
      end else begin
        sck_pin = 1'b1; quiet = 6;
        if (i == 0) model_load();
        wait_n(3);
        mosi_pin = bit_at(mw, i);
        wait_n(3);
        chk("R5 miso bit", {15'd0, miso_pin}, {15'd0, bit_at(m_cur, i)});
        sck_pin = 1'b0; quiet = 6;
        if (i == b - 1) begin
          m_rx = masked(mw); m_full = 1'b1;
        end
        wait_n(6);
      end
    end
  endtask

  task automatic extra_edges(input int n);
    for (int i = 0; i < n; i++) begin
      sck_pin = 1'b1; wait_n(6);
      sck_pin = 1'b0; wait_n(6);
    end
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    ctx = "R1";
    chk("R1 tx_empty", {15'd0, tx_empty}, 16'd1);
    chk("R1 rx_full", {15'd0, rx_full}, 16'd0);
    chk("R1 underrun", {15'd0, tx_underrun}, 16'd0);
    chk("R1 rx_word", rx_word, 16'd0);
    chk("R1 miso", {15'd0, miso_pin}, 16'd0);
    started = 1;
    wait_n(3);

    ctx = "R2 R3 8-bit msb phase0";
    host_write(16'h00A5); cs_low(); frame(16'h003C); cs_high();
    chk("R3 rx after frame", rx_word, 16'h003C);
    host_read();

    ctx = "R7 R6 8-bit lsb phase0";
    cfg_lsb_first = 1'b1;
    host_write(16'hFF1E); cs_low(); frame(16'h00C4); cs_high();
    chk("R6 upper byte zero", rx_word, 16'h00C4);
    host_read();

    ctx = "R6 16-bit msb phase0";
    cfg_lsb_first = 1'b0; cfg_wide = 1'b1;
    host_write(16'hBEEF); cs_low(); frame(16'h1234); cs_high();
    host_read();

    ctx = "R7 16-bit lsb phase0";
    cfg_lsb_first = 1'b1;
    host_write(16'h8001); cs_low(); frame(16'h7A5C); cs_high();
    host_read();

    ctx = "R4 R9 continuous select phase0";
    cfg_lsb_first = 1'b0; cfg_wide = 1'b0;
    host_write(16'h0011); cs_low(); host_write(16'h0033);
    frame(16'h0022); host_read();
    frame(16'h0044); host_read();
    frame(16'h0055);
    cs_high();
    chk("R9 underrun after repeat", {15'd0, tx_underrun}, 16'd1);
    host_read();

    ctx = "R5 8-bit msb phase1";
    cfg_cpha = 1'b1;
    host_write(16'h0096); cs_low(); frame(16'h0069);
    host_read();
    extra_edges(2);
    chk("R5 edges ignored", rx_word, 16'h0069);
    cs_high();

    ctx = "R5 R7 16-bit lsb phase1";
    cfg_wide = 1'b1; cfg_lsb_first = 1'b1;
    host_write(16'hC3A1); cs_low(); frame(16'h0F0F); cs_high();
    host_read();

    ctx = "R9 underrun phase1";
    cs_low(); frame(16'hFFFF); cs_high();
    chk("R9 underrun flag", {15'd0, tx_underrun}, 16'd1);
    host_read();

    wait_n(10);
    summary();
  end
endmodule